// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital side of a dual-slope (integrating) analog-to-digital converter. It drives three analog switch selects: integrator reset, unknown input, and negative reference. It times the first slope, counts the second, and returns the count as the conversion code. The integrator, the switches and the zero-volt comparator sit outside the block.

A conversion has three timed parts. A start pulse in the idle state first holds the integrator in reset for a fixed number of cycles. The unknown input is then applied for exactly 2^RES_BITS cycles. Finally the negative reference is applied while a counter runs until the comparator reports a return through zero. Because the charge time is 2^RES_BITS clocks, the run-down count is the RES_BITS-wide code (input = reference x count / 2^RES_BITS). The comparator is asynchronous to the clock, so it passes through a synchronizer before the state machine uses it.

States and transitions: IDLE goes to AUTOZERO on start. AUTOZERO goes to INTEGRATE when its timer expires. INTEGRATE goes to DEINTEGRATE when its timer expires. DEINTEGRATE goes to FINISH on a zero crossing or on count saturation. FINISH always returns to IDLE after one cycle.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset all switch selects, `done_o` and `ovr_o` are low, `result_o` is zero, and the controller is idle.
- R2: `start_i` high at a clock edge while idle makes `sw_zero_o` high from the next cycle for exactly AZ_CYCLES cycles.
- R3: Immediately after the reset phase, `sw_vin_o` is high for exactly 2^RES_BITS cycles, independent of the comparator.
- R4: Immediately after the input phase, `sw_vref_o` stays high until the run-down ends. At no time is more than one switch select high.
- R5: `cmp_i` passes through a two-flop synchronizer, and the code is the number of run-down clock edges at which the synchronized comparator still read high. If `cmp_i` falls after d run-down cycles (d >= 1), `result_o` = d + 2 and `sw_vref_o` lasts d + 3 cycles. If the comparator never rises, the result is 0 after one run-down cycle.
- R6: If the synchronized comparator is still high at the 2^RES_BITS-th run-down edge, the run-down ends there (`sw_vref_o` high for 2^RES_BITS cycles). `result_o` then becomes all ones and `ovr_o` becomes 1; otherwise `ovr_o` is 0.
- R7: `done_o` is a one-cycle pulse in the cycle after the run-down ends. The new `result_o` is visible in that same cycle, and the controller is idle in the next cycle.
- R8: `result_o` and `ovr_o` keep their value from one completion to the next, including during the following conversion.
- R9: `start_i` is ignored in every state other than idle: phase lengths are unchanged and no further conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled at rising edges |
| cmp_i | input | 1 | Comparator, high while the integrator output is above zero |
| sw_zero_o | output | 1 | Integrator reset switch select |
| sw_vin_o | output | 1 | Unknown-input switch select |
| sw_vref_o | output | 1 | Negative-reference switch select |
| result_o | output | RES_BITS | Conversion code |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Overrange flag of the last conversion |

## Verification
The bench models the comparator from the switch selects. It drives a fall after a chosen number of run-down cycles and checks the code against the synchronizer offset of R5. The directed edges are:
- **Zero input.** A design that counted before sampling would return a nonzero code.
- **Largest in-range input (code all ones with the flag clear).** An off-by-one saturation test would wrongly raise the overrange flag.
- **Inputs one step and well beyond the limit.** A counter that wrapped would return a small code.

Start requests during the input phase expose a controller that restarts or stretches a phase. Checking the previous code in the middle of the next conversion catches a result register that clears early.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_AZERO  = 3'd1,
        ST_INTEG  = 3'd2,
        ST_DEINT  = 3'd3,
        ST_FINISH = 3'd4
    } dsadc_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= d_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[g] <= 1'b0;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsadc_phase_timer.sv
module dsadc_phase_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic             expired_o
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R2/R3: a freshly loaded nonzero interval cannot be reported as expired
    AST_TMR_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o); // R3

endmodule

// File: rtl/dsadc_rundown.sv
module dsadc_rundown #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                above_zero_i,
    output logic                finish_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                ovr_o
);

    localparam logic [RES_BITS-1:0] CNT_MAX = {RES_BITS{1'b1}};

    logic [RES_BITS-1:0] cnt_q;
    logic [RES_BITS-1:0] result_q;
    logic                ovr_q;
    logic                at_limit;

    assign at_limit = (cnt_q == CNT_MAX);
    assign finish_o = active_i && (!above_zero_i || at_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i) begin
            cnt_q <= '0;
        end else if (above_zero_i && !at_limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ovr_q    <= 1'b0;
        end else if (finish_o) begin
            result_q <= above_zero_i ? CNT_MAX : cnt_q;
            ovr_q    <= above_zero_i;
        end
    end

    assign result_o = result_q;
    assign ovr_o    = ovr_q;

    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (result_o == CNT_MAX)); // R6

    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> (cnt_q == '0)); // R5

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int AZ_CYCLES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_i,
    output logic                sw_zero_o,
    output logic                sw_vin_o,
    output logic                sw_vref_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o,
    output logic                ovr_o
);

    localparam int INT_CYCLES = 1 << RES_BITS;
    localparam int TMR_SPAN   = max2(max2(AZ_CYCLES, INT_CYCLES), 2);
    localparam int TMR_W      = $clog2(TMR_SPAN);
    localparam logic [TMR_W-1:0] AZ_LOAD  = TMR_W'(AZ_CYCLES - 1);
    localparam logic [TMR_W-1:0] INT_LOAD = TMR_W'(INT_CYCLES - 1);

    dsadc_state_e     state_q, state_d;
    logic             cmp_sync;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_active;
    logic             rd_finish;

    dsadc_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_sync)
    );

    dsadc_phase_timer #(
        .WIDTH (TMR_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    dsadc_rundown #(
        .RES_BITS (RES_BITS)
    ) rundown_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (rd_active),
        .above_zero_i (cmp_sync),
        .finish_o     (rd_finish),
        .result_o     (result_o),
        .ovr_o        (ovr_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = AZ_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_AZERO;
                    tmr_load = 1'b1;
                    tmr_val  = AZ_LOAD;
                end
            end
            ST_AZERO: begin
                if (tmr_expired) begin
                    state_d  = ST_INTEG;
                    tmr_load = 1'b1;
                    tmr_val  = INT_LOAD;
                end
            end
            ST_INTEG: begin
                if (tmr_expired) begin
                    state_d = ST_DEINT;
                end
            end
            ST_DEINT: begin
                if (rd_finish) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        sw_zero_o = 1'b0;
        sw_vin_o  = 1'b0;
        sw_vref_o = 1'b0;
        done_o    = 1'b0;
        rd_active = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_AZERO:  sw_zero_o = 1'b1;
            ST_INTEG:  sw_vin_o  = 1'b1;
            ST_DEINT: begin
                sw_vref_o = 1'b1;
                rd_active = 1'b1;
            end
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    AST_SW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_zero_o, sw_vin_o, sw_vref_o})); // R4

    AST_START_TO_AZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> sw_zero_o); // R2

    AST_AZ_TO_VIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_zero_o) |-> sw_vin_o); // R3

    AST_VIN_TO_VREF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_vin_o) |-> sw_vref_o); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && state_q == ST_IDLE)); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovr_o))); // R8

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && start_i) |=> (state_q != ST_AZERO)); // R9

endmodule

// File: tb/dsadc_ctrl_tb_top.sv
`timescale 1ns/1ps
module dsadc_ctrl_tb_top;

    localparam int RB      = 8;
    localparam int AZ      = 16;
    localparam int INTC    = 1 << RB;
    localparam int FULL    = (1 << RB) - 1;
    localparam int WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cmp_i = 1'b0;
    logic          sw_zero_o, sw_vin_o, sw_vref_o;
    logic [RB-1:0] result_o;
    logic          done_o, ovr_o;

    int checks = 0;
    int errors = 0;
    int prev_res = 0;
    bit prev_ovr = 1'b0;

    always #2 clk = ~clk;

    dsadc_ctrl #(
        .RES_BITS    (RB),
        .AZ_CYCLES   (AZ),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .sw_zero_o (sw_zero_o),
        .sw_vin_o  (sw_vin_o),
        .sw_vref_o (sw_vref_o),
        .result_o  (result_o),
        .done_o    (done_o),
        .ovr_o     (ovr_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ovr(input int v);
        return (v > 0) && (v + 2 >= INTC);
    endfunction

    function automatic int exp_res(input int v);
        if (v == 0) return 0;
        if (exp_ovr(v)) return FULL;
        return v + 2;
    endfunction

    function automatic int exp_vref(input int v);
        if (v == 0) return 1;
        if (exp_ovr(v)) return INTC;
        return v + 3;
    endfunction

    task automatic run_conv(input int v, input bit poke);
        int az_n = 0;
        int vin_n = 0;
        int vref_n = 0;
        int done_n = 0;
        int rd = 0;
        int guard = 0;
        bit seen_done = 1'b0;
        bit hold_checked = 1'b0;
        bit excl_bad = 1'b0;
        bit fin = 1'b0;
        int held;
        @(negedge clk);
        start_i = 1'b1;
        cmp_i   = 1'b0;
        while (!fin) begin
            @(negedge clk);
            start_i = 1'b0;
            guard++;
            if ((int'(sw_zero_o) + int'(sw_vin_o) + int'(sw_vref_o)) > 1) excl_bad = 1'b1;
            if (sw_zero_o) az_n++;
            if (sw_vin_o) begin
                vin_n++;
                if (!hold_checked) begin
                    hold_checked = 1'b1;
                    chk(result_o == prev_res[RB-1:0], "R8", "code during next conversion",
                        int'(result_o), prev_res);
                    chk(ovr_o == prev_ovr, "R8", "flag during next conversion",
                        int'(ovr_o), int'(prev_ovr));
                end
                if (poke && vin_n >= 5 && vin_n < 12) start_i = 1'b1;
            end
            cmp_i = (v > 0) && (sw_vin_o || (sw_vref_o && rd < v));
            if (sw_vref_o) begin
                vref_n++;
                rd++;
            end
            if (done_o) begin
                done_n++;
                if (!seen_done) begin
                    chk(result_o == exp_res(v), "R5", $sformatf("code for v=%0d", v),
                        int'(result_o), exp_res(v));
                    chk(ovr_o == exp_ovr(v), "R6", $sformatf("overrange for v=%0d", v),
                        int'(ovr_o), int'(exp_ovr(v)));
                end
                seen_done = 1'b1;
            end else if (seen_done) begin
                fin = 1'b1;
            end
            if (guard > 5000) fin = 1'b1;
        end
        chk(!excl_bad, "R4", "switch selects exclusive", int'(excl_bad), 0);
        chk(az_n == AZ, "R2", "reset phase length", az_n, AZ);
        chk(vin_n == INTC, "R3", "input phase length", vin_n, INTC);
        chk(vref_n == exp_vref(v), exp_ovr(v) ? "R6" : "R4",
            $sformatf("run-down length v=%0d", v), vref_n, exp_vref(v));
        chk(done_n == 1, "R7", "done pulse width", done_n, 1);
        prev_res = exp_res(v);
        prev_ovr = exp_ovr(v);
        held = int'(result_o);
        repeat (3) @(negedge clk);
        chk(!(sw_zero_o || sw_vin_o || sw_vref_o), poke ? "R9" : "R7",
            "idle after completion", int'({sw_zero_o, sw_vin_o, sw_vref_o}), 0);
        chk(int'(result_o) == held && int'(result_o) == prev_res, "R8", "code held while idle",
            int'(result_o), prev_res);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected=completion", WD_LIMIT);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd7719);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!(sw_zero_o || sw_vin_o || sw_vref_o), "R1", "switches in reset",
            int'({sw_zero_o, sw_vin_o, sw_vref_o}), 0);
        chk(done_o == 1'b0 && ovr_o == 1'b0, "R1", "flags in reset",
            int'({done_o, ovr_o}), 0);
        chk(result_o == '0, "R1", "code in reset", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!(sw_zero_o || sw_vin_o || sw_vref_o || done_o), "R1", "idle after reset",
            int'({sw_zero_o, sw_vin_o, sw_vref_o, done_o}), 0);

        // directed edges: zero, smallest, largest in range, first and far overrange
        run_conv(0, 1'b0);
        run_conv(1, 1'b1);
        run_conv(FULL - 2, 1'b0);
        run_conv(FULL - 1, 1'b0);
        run_conv(400, 1'b1);
        run_conv(37, 1'b0);

        for (int i = 0; i < 22; i++) begin
            int v;
            v = int'($urandom % 300);
            run_conv(v, ($urandom % 3) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule